// File: doc/BRIEF.md
# Half-Precision Dual-Semantics Min/Max Selector

This block takes one pair of binary16 operands, `a` and `b`, together with a 2-bit operation code. It returns one of the two operands unchanged, plus a flag for an invalid operation. No new value is ever formed: the output is always a bit-exact copy of `a` or `b`.

Two families of selection share the datapath.

- **Plain forms (max, min).** These are order-dependent. A NaN in `a` is dropped and `b` is passed. A quiet NaN in `b` is passed through. Whenever the two values compare equal, `b` is returned.
- **Number-preferring forms (maxNum, minNum).** These are symmetric. When exactly one operand is a NaN, the other operand is returned.

Every form raises the invalid flag when either input is a signaling NaN. In that case it returns the numeric operand.

Operands enter through a valid/ready input channel and leave through a valid/ready output channel, with one register stage in between.

- An input is accepted on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or when its content is being taken in the same cycle.
- A result waits in the output register until `out_ready` is high. While it waits, it does not change.

Top module: `fp16_minmax_unit`

## Requirements
- R1: A pair accepted at a clock edge shows up with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_value` and `out_invalid` hold steady. `in_ready` is high exactly when the output register is empty or being drained.
- R2: Op code 00 selects plain max. For two ordered operands it returns the larger one, and it returns `b` when they are equal.
- R3: Op code 01 selects plain min. For two ordered operands it returns the smaller one, and it returns `b` when they are equal.
- R4: +0 and −0 compare equal, so every form returns operand `b` when both inputs are zeros of either sign.
- R5: In the plain forms, a NaN in `a` yields `b`.
- R6: In the plain forms, a quiet NaN in `b`, with a number in `a`, is returned bit-exact.
- R7: Op codes 10 (maxNum) and 11 (minNum) return the non-NaN operand when exactly one operand is a NaN, whichever side it is on.
- R8: When both operands are NaN, every form returns `b` bit-exact.
- R9: A signaling NaN has exponent bits [14:10] all ones, a nonzero fraction, and bit 9 clear. If either input is a signaling NaN, `out_invalid` is high. The numeric operand is returned when the other input is a number.
- R10: Quiet NaNs (bit 9 set) and ordinary values never raise `out_invalid`.
- R11: Ordering uses sign and magnitude, so −inf is below every number, +inf is above every number, and a more negative value is smaller.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_op | input | 2 | 00 max, 01 min, 10 maxNum, 11 minNum |
| in_a | input | 16 | Operand a (binary16) |
| in_b | input | 16 | Operand b (binary16) |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_value | output | 16 | Selected operand |
| out_invalid | output | 1 | A signaling NaN was seen |

## Verification
The checker watches several behaviours on every cycle:

- stall stability and delivery of each accepted pair;
- the invalid flag against the NaN class of the accepted inputs;
- the choice of `b` for NaN pairs and for zero ties;
- the number-wins choice of the maxNum/minNum forms.

The order-dependent results of the plain forms and the ordering of infinities and negative values are shown only by the bench scenarios, which compare each result with an independent model. Back-to-back transfers under an irregular `out_ready` pattern are also shown only by the bench.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int unsigned FMM_EXP_W = 5;
  localparam int unsigned FMM_MAN_W = 10;

  typedef enum logic [1:0] {
    OP_MAX    = 2'b00,
    OP_MIN    = 2'b01,
    OP_MAXNUM = 2'b10,
    OP_MINNUM = 2'b11
  } mm_op_e;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 10,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  output logic         sign,
  output logic [W-2:0] mag,
  output logic         is_zero,
  output logic         is_nan,
  output logic         is_snan
);
  logic exp_ones;
  logic frac_nz;

  always_comb begin
    sign     = val[W-1];
    mag      = val[W-2:0];
    exp_ones = &val[W-2:MAN_W];
    frac_nz  = |val[MAN_W-1:0];
    is_zero  = (mag == '0);
    is_nan   = exp_ones && frac_nz;
    // quiet bit is the top fraction bit
    is_snan  = is_nan && !val[MAN_W-1];
  end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int unsigned MW = 15
) (
  input  logic          sa,
  input  logic [MW-1:0] ma,
  input  logic          za,
  input  logic          sb,
  input  logic [MW-1:0] mb,
  input  logic          zb,
  output logic          a_gt_b,
  output logic          a_lt_b
);
  always_comb begin
    a_gt_b = 1'b0;
    a_lt_b = 1'b0;
    if (za && zb) begin
      // signed zeros are equal
      a_gt_b = 1'b0;
      a_lt_b = 1'b0;
    end else if (sa != sb) begin
      a_gt_b = !sa;
      a_lt_b = sa;
    end else if (!sa) begin
      a_gt_b = ma > mb;
      a_lt_b = ma < mb;
    end else begin
      a_gt_b = ma < mb;
      a_lt_b = ma > mb;
    end
  end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
  import fmm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  mm_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_nan,
  input  logic         a_snan,
  input  logic         b_nan,
  input  logic         b_snan,
  input  logic         a_gt_b,
  input  logic         a_lt_b,
  output logic [W-1:0] res,
  output logic         invalid
);
  logic want_min;
  logic num_form;
  logic cmp_pick_a;
  logic pick_a;

  always_comb begin
    want_min   = op[0];
    num_form   = op[1];
    cmp_pick_a = want_min ? a_lt_b : a_gt_b;
    pick_a     = 1'b0;
    if (num_form) begin
      if (a_nan)      pick_a = 1'b0;
      else if (b_nan) pick_a = 1'b1;
      else            pick_a = cmp_pick_a;
    end else begin
      if (a_nan)       pick_a = 1'b0;
      else if (b_snan) pick_a = 1'b1;
      else if (b_nan)  pick_a = 1'b0;
      else             pick_a = cmp_pick_a;
    end
    res     = pick_a ? a : b;
    invalid = a_snan || b_snan;
  end
endmodule

// File: rtl/fmm_stage.sv
module fmm_stage #(
  parameter int unsigned DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          take;

  always_comb begin
    up_ready = !full_q || dn_ready;
    take     = up_valid && up_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= up_data;
      end else if (dn_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/fp16_minmax_unit.sv
module fp16_minmax_unit
  import fmm_pkg::*;
#(
  parameter int unsigned EXP_W = FMM_EXP_W,
  parameter int unsigned MAN_W = FMM_MAN_W,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_value,
  output logic         out_invalid
);
  localparam int unsigned NOPND = 2;

  logic [W-1:0] opnd    [NOPND];
  logic         sgn     [NOPND];
  logic [W-2:0] mag     [NOPND];
  logic         zero    [NOPND];
  logic         nan     [NOPND];
  logic         snan    [NOPND];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar gi = 0; gi < NOPND; gi++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val     (opnd[gi]),
      .sign    (sgn[gi]),
      .mag     (mag[gi]),
      .is_zero (zero[gi]),
      .is_nan  (nan[gi]),
      .is_snan (snan[gi])
    );
  end

  logic a_gt_b, a_lt_b;

  fmm_order #(.MW(W-1)) u_ord (
    .sa     (sgn[0]),
    .ma     (mag[0]),
    .za     (zero[0]),
    .sb     (sgn[1]),
    .mb     (mag[1]),
    .zb     (zero[1]),
    .a_gt_b (a_gt_b),
    .a_lt_b (a_lt_b)
  );

  logic [W-1:0] sel_val;
  logic         sel_inv;

  fmm_select #(.W(W)) u_sel (
    .op      (mm_op_e'(in_op)),
    .a       (in_a),
    .b       (in_b),
    .a_nan   (nan[0]),
    .a_snan  (snan[0]),
    .b_nan   (nan[1]),
    .b_snan  (snan[1]),
    .a_gt_b  (a_gt_b),
    .a_lt_b  (a_lt_b),
    .res     (sel_val),
    .invalid (sel_inv)
  );

  logic [W:0] stage_out;

  fmm_stage #(.DW(W+1)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({sel_inv, sel_val}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (stage_out)
  );

  assign out_value   = stage_out[W-1:0];
  assign out_invalid = stage_out[W];
endmodule

// File: rtl/fmm_chk.sv
module fmm_chk #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 10,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_value,
  input logic         out_invalid
);
  function automatic logic f_nan(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic f_sig(input logic [W-1:0] x);
    return f_nan(x) && !x[MAN_W-1];
  endfunction

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_invalid));

  // R1
  deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9
  sig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (f_sig(in_a) || f_sig(in_b)) |=> out_invalid);

  // R10
  quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !f_sig(in_a) && !f_sig(in_b) |=> !out_invalid);

  // R8
  both_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && f_nan(in_a) && f_nan(in_b) |=> out_value == $past(in_b));

  // R4
  zero_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_a[W-2:0] == '0) && (in_b[W-2:0] == '0) |=> out_value == $past(in_b));

  // R7
  num_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op[1] && f_nan(in_a) && !f_nan(in_b) |=> out_value == $past(in_b));

  // R7
  num_wins_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op[1] && !f_nan(in_a) && f_nan(in_b) |=> out_value == $past(in_a));
endmodule

bind fp16_minmax_unit fmm_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_value   (out_value),
  .out_invalid (out_invalid)
);

// File: tb/fp16_minmax_unit_test.sv
module fp16_minmax_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_value;
  logic        out_invalid;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] val;
    logic        inv;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp16_minmax_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_value(out_value), .out_invalid(out_invalid)
  );

  // reference model written from the requirements
  function automatic bit m_isnan(input logic [15:0] x);
    return (x[14:10] == 5'h1f) && (x[9:0] != 10'h0);
  endfunction
  function automatic bit m_issig(input logic [15:0] x);
    return m_isnan(x) && (x[9] == 1'b0);
  endfunction
  // signed value rank: -1 a<b, 0 equal, 1 a>b
  function automatic int m_rank(input logic [15:0] a, input logic [15:0] b);
    int ka, kb;
    ka = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
    kb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
    if (ka < kb) return -1;
    if (ka > kb) return 1;
    return 0;
  endfunction
  function automatic logic [16:0] m_ref(input logic [1:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    logic [15:0] r;
    int k;
    bit inv;
    inv = m_issig(a) || m_issig(b);
    if (m_isnan(a)) r = b;
    else if (m_isnan(b)) r = (op[1] || m_issig(b)) ? a : b;
    else begin
      k = m_rank(a, b);
      if (op[0]) r = (k < 0) ? a : b;
      else       r = (k > 0) ? a : b;
    end
    return {inv, r};
  endfunction

  task automatic send(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                      input string tag);
    logic [16:0] e;
    exp_t it;
    e = m_ref(op, a, b);
    it.val = e[15:0];
    it.inv = e[16];
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    in_valid = 1'b1;
    in_op = op;
    in_a = a;
    in_b = b;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // monitor: drives out_ready, compares head of scoreboard
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (rst_n && out_valid) begin
        n_cmp++;
        if (sb_q.size() == 0) begin
          n_bad++;
          $display("FAIL R1: unexpected result %h, expected none", out_value);
        end else begin
          if (out_value !== sb_q[0].val || out_invalid !== sb_q[0].inv) begin
            n_bad++;
            $display("FAIL %s: got %h/%b expected %h/%b", sb_q[0].tag,
                     out_value, out_invalid, sb_q[0].val, sb_q[0].inv);
          end
          if (out_ready) void'(sb_q.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R12: got valid=%b ready=%b expected 0/1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      send(2'b00, 16'h4000, 16'h4200, "R2");      // max(2,3)
      send(2'b00, 16'h4200, 16'h4000, "R2");
      send(2'b00, 16'hC000, 16'hC200, "R2");      // max(-2,-3) = -2
      send(2'b00, 16'h4000, 16'h4000, "R2");
      send(2'b01, 16'h4000, 16'h4200, "R3");
      send(2'b01, 16'hC000, 16'hC200, "R3");      // min(-2,-3) = -3
      send(2'b01, 16'h3C00, 16'h4000, "R3");
      send(2'b00, 16'h0000, 16'h8000, "R4");
      send(2'b00, 16'h8000, 16'h0000, "R4");
      send(2'b01, 16'h0000, 16'h8000, "R4");
      send(2'b11, 16'h8000, 16'h0000, "R4");
      send(2'b00, 16'h7E11, 16'h4200, "R5");
      send(2'b01, 16'h7E11, 16'h4200, "R5");
      send(2'b00, 16'h4200, 16'h7E55, "R6");
      send(2'b01, 16'h4200, 16'h7E55, "R6");
      send(2'b10, 16'h7E11, 16'h4200, "R7");
      send(2'b10, 16'h4200, 16'h7E55, "R7");
      send(2'b11, 16'h4200, 16'h7E55, "R7");
      send(2'b11, 16'h7E11, 16'hC200, "R7");
      for (int op = 0; op < 4; op++) send(op[1:0], 16'h7E11, 16'h7E55, "R8");
      send(2'b00, 16'h7D00, 16'h4200, "R9");
      send(2'b00, 16'h4200, 16'h7C01, "R9");
      send(2'b10, 16'h4200, 16'h7C01, "R9");
      send(2'b11, 16'h7D00, 16'h4200, "R9");
      send(2'b10, 16'hFE00, 16'h3C00, "R10");
      send(2'b00, 16'hFC00, 16'hC200, "R11");
      send(2'b01, 16'hFC00, 16'hC200, "R11");
      send(2'b00, 16'h7C00, 16'h7BFF, "R11");
      send(2'b11, 16'h7C00, 16'hFC00, "R11");
      send(2'b01, 16'h8001, 16'h0001, "R11");
    end

    for (int w = 0; w < 200 && (sb_q.size() != 0 || out_valid); w++) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: got %0d results outstanding, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule